// File: doc/BRIEF.md
# Dual Input Capture Timer

This block runs a pair of 16-bit down-counters in a dual-capture mode. An external clock unit supplies a separate count-enable strobe for each counter. Two pin inputs, A and B, are synchronized and checked for edges. On a selected edge of pin B, both counters are copied into their own capture registers and a capture-event flag pulses for one cycle. On a selected edge of pin A, counter I is preset to all ones. Pin A can therefore mark the start of a measurement and pin B its end.

A small word-wide register port gives read and write access to both counters, both capture registers and a control register. The control register holds the operating-mode field, one edge-polarity bit per pin and one enable bit per pin. The mode field can hold four encodings, but the block acts only on the dual-capture encoding. With any other encoding, strobes and pin edges have no effect. The counters and the capture registers are not reset. Software loads them before use.

Top module: `dual_capture_timer`

## Requirements
- R1: After reset, the control register (address 4) reads 0000 and `cap_flag` is low.
- R2: Control register bits [1:0] hold the mode: 00, 01, 10 or 11. Bit 2 is the pin-A polarity, bit 3 the pin-B polarity, bit 4 the pin-A enable and bit 5 the pin-B enable. Only mode 01 lets strobes and pin edges act. In the other three modes the counters, the capture registers and `cap_flag` do not change unless written.
- R3: In mode 01, each cycle with `cnt1_tick` (or `cnt2_tick`) high decrements counter I (or counter II) by one, and 0000 wraps to FFFF.
- R4: In mode 01 with the pin-A enable set, a selected pin-A edge presets counter I to FFFF. The polarity bit selects falling edges when 0 and rising edges when 1.
- R5: In mode 01 with the pin-B enable set, a selected pin-B edge copies counter I into capture register A and counter II into capture register B, and drives `cap_flag` high for one cycle. Pin-B polarity has the same meaning as pin-A polarity.
- R6: When a pin's enable bit is clear, and for edges of the unselected direction, that pin causes no preset, no capture and no flag.
- R7: When a pin-A preset and a counter-I strobe occur in the same cycle, counter I becomes FFFF.
- R8: A register write to a counter in the same cycle as its strobe loads the written value and ignores the strobe.
- R9: A pin change sampled at clock edge k takes effect at clock edge k+2 (two synchronizer flops and one edge-detect flop), and `cap_flag` is high during the cycle that follows edge k+2.
- R10: Addresses 0, 1, 2 and 3 select counter I, counter II, capture A and capture B, and all four are fully readable and writable. Writes to address 4 keep bits [5:0], and the upper bits of address 4 read as 0.
- R11: When a capture and a register write to a capture register occur in the same cycle, the capture value is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt1_tick | input | 1 | Count-enable strobe for counter I |
| cnt2_tick | input | 1 | Count-enable strobe for counter II |
| pin_a | input | 1 | Asynchronous preset input |
| pin_b | input | 1 | Asynchronous capture input |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| cap_flag | output | 1 | One-cycle capture-event pulse |

## Verification
The assertions check the following on every cycle:
- A capture pulse coincides with capture registers holding the previous cycle's counts.
- Each strobe decrements a counter by exactly one, including the wrap.
- A write to a counter overrides a strobe, and a preset overrides a strobe.
- A non-capture mode freezes the counters and the flag.

Some behaviours need the bench's directed scenarios:
- the synchronizer latency;
- the polarity and enable combinations for each pin;
- the register map;
- the rejection of edges in the unselected direction.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_PWM     = 2'b00,
    MODE_DUALCAP = 2'b01,
    MODE_DUALTMR = 2'b10,
    MODE_CAPTMR  = 2'b11
  } mode_e;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CNT1 = 3'd0,
    SEL_CNT2 = 3'd1,
    SEL_CAPA = 3'd2,
    SEL_CAPB = 3'd3,
    SEL_CTRL = 3'd4
  } sel_e;

  typedef struct packed {
    logic  en_b;
    logic  en_a;
    logic  pol_b;
    logic  pol_a;
    mode_e mode;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/dct_pin_sync.sv
module dct_pin_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol_rise,
  input  logic pin_en,
  input  logic active,
  output logic evt
);

  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;
  logic               rise;
  logic               fall;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  always_comb begin
    rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    fall = ~chain_q[SYNC_STAGES-1] & chain_q[SYNC_STAGES];
    evt  = active & pin_en & (pol_rise ? rise : fall);
  end

endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         preset,
  input  logic         step,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;
  logic         load;

  always_comb begin
    load = wr_en | preset | step;
    if (wr_en) begin
      q_d = wr_data;
    end else if (preset) begin
      q_d = '1;
    end else begin
      q_d = q - {{(W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/dct_capture_reg.sv
module dct_capture_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         cap_en,
  input  logic [W-1:0] cap_data,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;
  logic         load;

  always_comb begin
    load = cap_en | wr_en;
    q_d  = cap_en ? cap_data : wr_data;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer
  import dct_pkg::*;
#(
  parameter int unsigned W           = DATA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt1_tick,
  input  logic              cnt2_tick,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              cap_flag
);

  localparam int unsigned PAD_W = W - CTRL_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_q_n = rst_pipe_q[1];

  // register decode
  logic wr_cnt1, wr_cnt2, wr_capa, wr_capb, wr_ctrl;

  always_comb begin
    wr_cnt1 = bus_wr && (bus_addr == SEL_CNT1);
    wr_cnt2 = bus_wr && (bus_addr == SEL_CNT2);
    wr_capa = bus_wr && (bus_addr == SEL_CAPA);
    wr_capb = bus_wr && (bus_addr == SEL_CAPB);
    wr_ctrl = bus_wr && (bus_addr == SEL_CTRL);
  end

  // control register
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  mode_dc;

  always_comb begin
    ctrl_d = ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign mode_dc = (ctrl_q.mode == MODE_DUALCAP);

  // pin event detection
  logic preset_evt;
  logic cap_evt;

  dct_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync_a (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .pin      (pin_a),
    .pol_rise (ctrl_q.pol_a),
    .pin_en   (ctrl_q.en_a),
    .active   (mode_dc),
    .evt      (preset_evt)
  );

  dct_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync_b (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .pin      (pin_b),
    .pol_rise (ctrl_q.pol_b),
    .pin_en   (ctrl_q.en_b),
    .active   (mode_dc),
    .evt      (cap_evt)
  );

  // counters
  logic [W-1:0] cnt1_q, cnt2_q;

  dct_counter #(.W(W)) u_cnt1 (
    .clk     (clk),
    .wr_en   (wr_cnt1),
    .wr_data (bus_wdata),
    .preset  (preset_evt),
    .step    (cnt1_tick & mode_dc),
    .q       (cnt1_q)
  );

  dct_counter #(.W(W)) u_cnt2 (
    .clk     (clk),
    .wr_en   (wr_cnt2),
    .wr_data (bus_wdata),
    .preset  (1'b0),
    .step    (cnt2_tick & mode_dc),
    .q       (cnt2_q)
  );

  // capture registers
  logic [W-1:0] capa_q, capb_q;

  dct_capture_reg #(.W(W)) u_capa (
    .clk      (clk),
    .cap_en   (cap_evt),
    .cap_data (cnt1_q),
    .wr_en    (wr_capa),
    .wr_data  (bus_wdata),
    .q        (capa_q)
  );

  dct_capture_reg #(.W(W)) u_capb (
    .clk      (clk),
    .cap_en   (cap_evt),
    .cap_data (cnt2_q),
    .wr_en    (wr_capb),
    .wr_data  (bus_wdata),
    .q        (capb_q)
  );

  // capture flag
  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = cap_evt;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign cap_flag = flag_q;

  // read mux
  always_comb begin
    case (bus_addr)
      SEL_CNT1: bus_rdata = cnt1_q;
      SEL_CNT2: bus_rdata = cnt2_q;
      SEL_CAPA: bus_rdata = capa_q;
      SEL_CAPB: bus_rdata = capb_q;
      SEL_CTRL: bus_rdata = {{PAD_W{1'b0}}, ctrl_q};
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dct_checker.sv
module dct_checker
  import dct_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              mode_dc,
  input logic              cnt1_tick,
  input logic              cnt2_tick,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      cnt1_q,
  input logic [W-1:0]      cnt2_q,
  input logic [W-1:0]      capa_q,
  input logic [W-1:0]      capb_q,
  input logic              cap_flag,
  input logic              preset_evt
);

  logic w1, w2;
  assign w1 = bus_wr && (bus_addr == SEL_CNT1);
  assign w2 = bus_wr && (bus_addr == SEL_CNT2);

  p_capture_a_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    cap_flag |-> capa_q == $past(cnt1_q));

  p_capture_b_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    cap_flag |-> capb_q == $past(cnt2_q));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mode_dc && cnt2_tick && !w2) |=> cnt2_q == $past(cnt2_q) - 16'd1);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mode_dc && cnt2_tick && !w2 && cnt2_q == '0) |=> cnt2_q == '1);

  p_preset_wins_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (preset_evt && !w1) |=> cnt1_q == '1);

  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    w1 |=> cnt1_q == $past(bus_wdata));

  p_idle_count_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!mode_dc && !w1) |=> $stable(cnt1_q));

  p_idle_flag_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !mode_dc |=> !cap_flag);

endmodule

bind dual_capture_timer dct_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .mode_dc    (mode_dc),
  .cnt1_tick  (cnt1_tick),
  .cnt2_tick  (cnt2_tick),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .cnt1_q     (cnt1_q),
  .cnt2_q     (cnt2_q),
  .capa_q     (capa_q),
  .capb_q     (capb_q),
  .cap_flag   (cap_flag),
  .preset_evt (preset_evt)
);

// File: tb/tb_dual_capture_timer.sv
module tb_dual_capture_timer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt1_tick, cnt2_tick, pin_a, pin_b, bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        cap_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_capture_timer dut (
    .clk(clk), .rst_n(rst_n), .cnt1_tick(cnt1_tick), .cnt2_tick(cnt2_tick),
    .pin_a(pin_a), .pin_b(pin_b), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_flag(cap_flag)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic strobe(input int n, input logic e1, input logic e2);
    repeat (n) begin
      @(negedge clk);
      cnt1_tick = e1; cnt2_tick = e2;
    end
    @(negedge clk);
    cnt1_tick = 1'b0; cnt2_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drives a pin, returns at the negedge where an event's flag is visible
  task automatic pin_go(input bit is_a, input logic lvl, output logic flag_seen);
    @(negedge clk);
    if (is_a) pin_a = lvl; else pin_b = lvl;
    repeat (3) @(negedge clk);
    flag_seen = cap_flag;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=finished");
    report();
  end

  initial begin
    logic f;
    logic [15:0] e;
    rst_n = 1'b0; cnt1_tick = 0; cnt2_tick = 0; pin_a = 0; pin_b = 0;
    bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk_reg("R1 ctrl after reset", 3'd4, 16'h0000);
    check("R1 flag after reset", {15'd0, cap_flag}, 16'd0);

    // R10 register map
    wr(3'd0, 16'hA5C3); wr(3'd1, 16'h3C5A); wr(3'd2, 16'h0F0F); wr(3'd3, 16'hF0F0);
    wr(3'd4, 16'hFFFF);
    chk_reg("R10 cnt1", 3'd0, 16'hA5C3);
    chk_reg("R10 cnt2", 3'd1, 16'h3C5A);
    chk_reg("R10 capa", 3'd2, 16'h0F0F);
    chk_reg("R10 capb", 3'd3, 16'hF0F0);
    chk_reg("R10 ctrl masked", 3'd4, 16'h003F);

    // R2 mode sweep: rising-edge, both pins enabled
    for (int m = 0; m < 4; m++) begin
      wr(3'd4, 16'h0000);
      pin_a = 0; pin_b = 0; idle(4);
      wr(3'd4, 16'(6'b111100 | m));
      wr(3'd0, 16'h1234); wr(3'd1, 16'h0100); wr(3'd2, 16'hAAAA); wr(3'd3, 16'hBBBB);
      strobe(3, 1, 1);
      pin_go(0, 1'b1, f);
      check($sformatf("R2 flag mode=%0d", m), {15'd0, f}, (m == 1) ? 16'd1 : 16'd0);
      pin_go(1, 1'b1, f);
      idle(1);
      chk_reg($sformatf("R2 capa mode=%0d", m), 3'd2, (m == 1) ? 16'h1231 : 16'hAAAA);
      chk_reg($sformatf("R2 capb mode=%0d", m), 3'd3, (m == 1) ? 16'h00FD : 16'hBBBB);
      chk_reg($sformatf("R2 cnt1 mode=%0d", m), 3'd0, (m == 1) ? 16'hFFFF : 16'h1234);
      chk_reg($sformatf("R2 cnt2 mode=%0d", m), 3'd1, (m == 1) ? 16'h00FD : 16'h0100);
    end

    // R3 decrement/wrap sweep
    wr(3'd4, 16'h0001);
    for (int k = 0; k < 4; k++) begin
      for (int n = 1; n <= 5; n++) begin
        wr(3'd0, 16'(k)); wr(3'd1, 16'(k + 16'h8000));
        strobe(n, 1, (n % 2) == 1);
        e = 16'(k - n);
        chk_reg($sformatf("R3 cnt1 k=%0d n=%0d", k, n), 3'd0, e);
        e = 16'(k + 16'h8000 - (((n % 2) == 1) ? n : 0));
        chk_reg($sformatf("R3 cnt2 k=%0d n=%0d", k, n), 3'd1, e);
      end
    end

    // R4 R5 R6 polarity/enable sweep per pin
    for (int p = 0; p < 2; p++) begin
      for (int en = 0; en < 2; en++) begin
        logic start;
        start = (p == 0);
        // pin B
        wr(3'd4, 16'h0001 | 16'(p << 3) | 16'(en << 5));
        pin_b = start; idle(4);
        wr(3'd0, 16'h4321); wr(3'd1, 16'h0777); wr(3'd2, 16'h0000); wr(3'd3, 16'h0000);
        pin_go(0, ~start, f);
        check($sformatf("R5 R6 flag pol=%0d en=%0d", p, en), {15'd0, f}, 16'(en));
        idle(1);
        check($sformatf("R5 flag one cycle pol=%0d", p), {15'd0, cap_flag}, 16'd0);
        chk_reg($sformatf("R5 R6 capa pol=%0d en=%0d", p, en), 3'd2, en ? 16'h4321 : 16'h0);
        chk_reg($sformatf("R5 R6 capb pol=%0d en=%0d", p, en), 3'd3, en ? 16'h0777 : 16'h0);
        wr(3'd2, 16'h0000);
        pin_go(0, start, f);
        idle(1);
        check($sformatf("R6 reverse edge flag pol=%0d", p), {15'd0, f}, 16'd0);
        chk_reg($sformatf("R6 reverse edge capa pol=%0d", p), 3'd2, 16'h0000);
        // pin A
        wr(3'd4, 16'h0001 | 16'(p << 2) | 16'(en << 4));
        pin_a = start; idle(4);
        wr(3'd0, 16'h0123);
        pin_go(1, ~start, f);
        chk_reg($sformatf("R4 R6 cnt1 pol=%0d en=%0d", p, en), 3'd0, en ? 16'hFFFF : 16'h0123);
        wr(3'd0, 16'h0123);
        pin_go(1, start, f);
        chk_reg($sformatf("R6 reverse edge cnt1 pol=%0d", p), 3'd0, 16'h0123);
      end
    end

    // R9 latency on pin B
    wr(3'd4, 16'h0029);  // mode 01, pol_b=1, en_b=1
    pin_b = 0; idle(4);
    wr(3'd0, 16'h0400); wr(3'd2, 16'h0000);
    @(negedge clk); pin_b = 1;
    idle(2);
    check("R9 no flag before edge k+2", {15'd0, cap_flag}, 16'd0);
    chk_reg("R9 capa not yet", 3'd2, 16'h0000);
    idle(1);
    check("R9 flag after edge k+2", {15'd0, cap_flag}, 16'd1);
    chk_reg("R9 capa after edge k+2", 3'd2, 16'h0400);

    // R11 capture beats write to capture A
    pin_b = 0; idle(4);
    wr(3'd0, 16'h0321);
    @(negedge clk); pin_b = 1;
    idle(2);
    bus_wr = 1; bus_addr = 3'd2; bus_wdata = 16'h5555;
    @(negedge clk); bus_wr = 0;
    chk_reg("R11 capture over write", 3'd2, 16'h0321);

    // R7 preset beats strobe
    wr(3'd4, 16'h0015);  // mode 01, pol_a=1, en_a=1
    pin_a = 0; idle(4);
    wr(3'd0, 16'h0050);
    @(negedge clk); pin_a = 1;
    idle(2);
    cnt1_tick = 1;
    @(negedge clk); cnt1_tick = 0;
    chk_reg("R7 preset over strobe", 3'd0, 16'hFFFF);

    // R8 write beats strobe
    @(negedge clk);
    bus_wr = 1; bus_addr = 3'd0; bus_wdata = 16'h0777; cnt1_tick = 1;
    @(negedge clk);
    bus_wr = 0; cnt1_tick = 0;
    chk_reg("R8 write over strobe", 3'd0, 16'h0777);

    report();
  end

endmodule